// File: doc/BRIEF.md
# Self-Timed Wired-OR Bus Contender

This block is the logic that one device carries in a bus arbitration scheme with no central arbiter. Every device that may want the bus has a fixed identifier strapped onto `node_id`. A device raises `req_in` to make a request pending. When the shared `arb_start` strobe is seen, every device with a pending request drives its identifier onto a group of shared open-collector lines. The bench, or the board, ORs all drivers together and returns the result on `arb_lines`.

Each clock of a round, the node looks for the most significant bit where the lines carry a 1 but its own identifier has a 0. That bit shows that some rival ranks higher. The node stops driving that bit and every bit below it. It drives its full identifier again as soon as the conflict goes away, so a rival that has itself backed off cannot cause a false withdrawal. After a fixed number of settle cycles, the node compares the lines with its own identifier. If they are equal it wins, and otherwise it loses. The highest identifier taking part always ends up alone on the lines. A losing node keeps its request and tries again at the next strobe.

Top module: `arb_node`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `won`, `lost`, `pending` and `arb_drive` are all 0.
- R2: Outside a round, `arb_drive` is 0.
- R3: In the first cycle of a round, `arb_drive` equals `node_id` in full.
- R4: During a round, let p be the highest bit where `arb_lines` is 1 and `node_id` is 0. On the next cycle the node drives none of bits p down to 0. With no such bit, it drives all of `node_id`.
- R5: A round begins on the clock edge where `arb_start` is high, the node is idle, `pending` or `req_in` is 1, and `node_id` is nonzero. Exactly SETTLE_CYC edges later, exactly one of `won` or `lost` is high, for one cycle only.
- R6: `won` is raised if `arb_lines` equal `node_id` at the deciding edge. Among contenders with distinct identifiers, the one with the highest identifier wins.
- R7: A node whose `node_id` is 0 never drives, never starts a round, and never raises `won` or `lost`.
- R8: After `lost`, `pending` stays 1, and the next qualifying `arb_start` starts a new round.
- R9: `won` clears `pending`, unless `req_in` is high on the deciding edge. A `req_in` pulse at any time sets `pending`.
- R10: `arb_start` has no effect while a round is in progress. The decision edge stays SETTLE_CYC edges after the round began.
- R11: `arb_start` with no pending request and no `req_in` starts no round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W | Fixed identifier of this node; 0 means it never contends |
| req_in | input | 1 | One-cycle pulse that makes a request pending |
| arb_start | input | 1 | Shared strobe that starts a round |
| arb_lines | input | ID_W | Resolved OR of all nodes' drives |
| arb_drive | output | ID_W | This node's contribution to the wired-OR lines |
| won | output | 1 | One-cycle pulse: this node owns the bus |
| lost | output | 1 | One-cycle pulse: another node owns the bus |
| pending | output | 1 | A request is waiting for a win |

## Verification
The bench builds three nodes with ID_W = 4 and SETTLE_CYC = 8, and ties them together with a behavioural wired-OR. Eight settle cycles are enough for every four-bit conflict to resolve. With these values the bench can reach cases where a winner is wrongly blocked for a while by a rival that later backs off, as with 10 against 5. It also covers three-way contests, a zero identifier, and repeated rounds in which each loser returns until the lowest identifier finally wins.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ARB  = 1'b1
    } phase_e;

    typedef struct packed {
        logic won;
        logic lost;
    } verdict_t;
endpackage

// File: rtl/arb_withdraw.sv
module arb_withdraw #(
    parameter int ID_W = 4
) (
    input  logic [ID_W-1:0] my_id,
    input  logic [ID_W-1:0] lines,
    output logic [ID_W-1:0] keep
);
    // a rival outranks us at bit i when the line is high where our id is low
    logic [ID_W-1:0] outranked;
    assign outranked = lines & ~my_id;

    // keep bit i only if no outranking bit exists at i or above
    for (genvar gi = 0; gi < ID_W; gi++) begin : g_keep
        assign keep[gi] = ~(|outranked[ID_W-1:gi]);
    end
endmodule

// File: rtl/arb_round_ctl.sv
module arb_round_ctl
    import busarb_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic active,
    output logic decide
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign active = (phase_q == PH_ARB);
    assign decide = active && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (!active) begin
            if (launch) begin
                phase_q <= PH_ARB;
                cnt_q   <= '0;
            end
        end else if (decide) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/arb_node.sv
module arb_node
    import busarb_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] node_id,
    input  logic            req_in,
    input  logic            arb_start,
    input  logic [ID_W-1:0] arb_lines,
    output logic [ID_W-1:0] arb_drive,
    output logic            won,
    output logic            lost,
    output logic            pending
);
    logic            pend_q;
    logic [ID_W-1:0] mask_q;
    logic [ID_W-1:0] keep;
    verdict_t        verdict_q;
    logic            active;
    logic            decide;
    logic            launch;
    logic            id_valid;
    logic            match;

    assign id_valid = |node_id;
    assign launch   = arb_start && (pend_q || req_in) && id_valid;
    assign match    = (arb_lines == node_id);

    arb_withdraw #(.ID_W(ID_W)) u_withdraw (
        .my_id (node_id),
        .lines (arb_lines),
        .keep  (keep)
    );

    arb_round_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .active (active),
        .decide (decide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            mask_q    <= '1;
            verdict_q <= '0;
        end else begin
            verdict_q.won  <= decide && match;
            verdict_q.lost <= decide && !match;
            if (!active) begin
                mask_q <= '1;
            end else begin
                mask_q <= keep;
            end
            pend_q <= (pend_q && !(decide && match)) || req_in;
        end
    end

    assign arb_drive = active ? (node_id & mask_q) : '0;
    assign won       = verdict_q.won;
    assign lost      = verdict_q.lost;
    assign pending   = pend_q;
endmodule

// File: rtl/arb_node_chk.sv
module arb_node_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [ID_W-1:0] node_id,
    input logic            req_in,
    input logic [ID_W-1:0] arb_drive,
    input logic            won,
    input logic            lost,
    input logic            pending
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!won && !lost && !pending && arb_drive == '0));

    // R5
    single_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !(won && lost));

    // R5
    won_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        won |=> !won);

    // R5
    lost_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lost |=> !lost);

    // R7
    zero_id_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (node_id == '0) |-> (arb_drive == '0 && !won && !lost));

    // R8
    loser_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        lost |-> pending);

    // R9
    winner_clears_chk: assert property (@(posedge clk) disable iff (rst)
        won |-> (!pending || $past(req_in)));
endmodule

bind arb_node arb_node_chk #(.ID_W(ID_W)) u_arb_node_chk (
    .clk       (clk),
    .rst       (rst),
    .node_id   (node_id),
    .req_in    (req_in),
    .arb_drive (arb_drive),
    .won       (won),
    .lost      (lost),
    .pending   (pending)
);

// File: tb/arb_node_bench.sv
module arb_node_bench;
    localparam int ID_W  = 4;
    localparam int S     = 8;
    localparam int NODES = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            arb_start = 1'b0;
    logic [ID_W-1:0] ids  [NODES];
    logic            reqs [NODES];
    logic [ID_W-1:0] drv  [NODES];
    logic            wn   [NODES];
    logic            ls   [NODES];
    logic            pd   [NODES];
    logic [ID_W-1:0] lines;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    // wired-OR of all nodes
    always_comb begin
        lines = '0;
        for (int i = 0; i < NODES; i++) lines = lines | drv[i];
    end

    for (genvar g = 0; g < NODES; g++) begin : g_node
        if (g == 0) begin : g_dut
            arb_node #(.ID_W(ID_W), .SETTLE_CYC(S)) u_arb_node (
                .clk(clk), .rst(rst), .node_id(ids[g]), .req_in(reqs[g]),
                .arb_start(arb_start), .arb_lines(lines), .arb_drive(drv[g]),
                .won(wn[g]), .lost(ls[g]), .pending(pd[g]));
        end else begin : g_peer
            arb_node #(.ID_W(ID_W), .SETTLE_CYC(S)) u_peer (
                .clk(clk), .rst(rst), .node_id(ids[g]), .req_in(reqs[g]),
                .arb_start(arb_start), .arb_lines(lines), .arb_drive(drv[g]),
                .won(wn[g]), .lost(ls[g]), .pending(pd[g]));
        end
    end

    // behavioural reference
    bit m_pend [NODES];
    bit m_busy [NODES];
    int m_cnt  [NODES];
    bit m_won  [NODES];
    bit m_lost [NODES];
    int m_best;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NODES; i++) begin
                m_pend[i] = 0; m_busy[i] = 0; m_cnt[i] = 0;
                m_won[i] = 0; m_lost[i] = 0;
            end
        end else begin
            bit starting [NODES];
            bit winning  [NODES];
            int best_now;
            best_now = 0;
            for (int i = 0; i < NODES; i++) begin
                starting[i] = !m_busy[i] && arb_start && (m_pend[i] || reqs[i])
                              && (ids[i] != 0);
                if (starting[i] && int'(ids[i]) > best_now) best_now = int'(ids[i]);
            end
            if (best_now != 0) m_best = best_now;
            for (int i = 0; i < NODES; i++) begin
                m_won[i] = 0; m_lost[i] = 0; winning[i] = 0;
                if (m_busy[i]) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == S) begin
                        m_busy[i] = 0;
                        winning[i] = (int'(ids[i]) == m_best);
                        m_won[i] = winning[i];
                        m_lost[i] = !winning[i];
                    end
                end else if (starting[i]) begin
                    m_busy[i] = 1; m_cnt[i] = 0;
                end
                m_pend[i] = (m_pend[i] && !winning[i]) || reqs[i];
            end
        end
    end

    task automatic cmp(input string req, input int node, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s node%0d: actual %0d expected %0d at %0t", req, node, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        for (int i = 0; i < NODES; i++) begin
            // R5 R6 R7 R10 R11 verdict pulses
            cmp("R6", i, int'(wn[i]), int'(m_won[i]));
            cmp("R5", i, int'(ls[i]), int'(m_lost[i]));
            // R8 R9 pending
            cmp("R9", i, int'(pd[i]), int'(m_pend[i]));
            if (!m_busy[i]) cmp("R2", i, int'(drv[i]), 0);
            else if (m_cnt[i] == 0) cmp("R3", i, int'(drv[i]), int'(ids[i]));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input bit r0, input bit r1, input bit r2);
        @(negedge clk);
        reqs[0] = r0; reqs[1] = r1; reqs[2] = r2;
        @(negedge clk);
        for (int i = 0; i < NODES; i++) reqs[i] = 0;
    endtask

    task automatic strobe();
        @(negedge clk); arb_start = 1'b1;
        @(negedge clk); arb_start = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NODES; i++) begin reqs[i] = 0; ids[i] = '0; end
        tick(3);
        rst = 1'b0;                       // R1 checked via reset-cycle compares
        // R6: 5 against 6 -> 6 wins
        ids[0] = 4'd5; ids[1] = 4'd6; ids[2] = 4'd0;
        request(1, 1, 0); strobe(); tick(S + 3);
        // R8: the loser 5 returns alone and wins
        strobe(); tick(S + 3);
        // R4 R6: 10 against 5 against 3, then re-entry order 10, 5, 3
        ids[0] = 4'd10; ids[1] = 4'd5; ids[2] = 4'd3;
        request(1, 1, 1);
        for (int k = 0; k < 3; k++) begin strobe(); tick(S + 3); end
        // R10: strobe in mid-round ignored; R9: request during round kept
        ids[0] = 4'd15; ids[1] = 4'd14; ids[2] = 4'd1;
        request(1, 1, 1); strobe(); tick(2);
        strobe(); request(1, 0, 0); tick(S + 3);
        // R7: zero identifier never contends
        ids[0] = 4'd0;
        strobe(); tick(S + 3);
        strobe(); tick(S + 3);
        // R11: no pending anywhere -> nothing happens
        strobe(); tick(S + 3);
        // R1: reset in the middle of a round
        ids[0] = 4'd9; request(1, 0, 0); strobe(); tick(3);
        @(negedge clk) rst = 1'b1; tick(2); rst = 1'b0; tick(S + 3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule